// File: doc/BRIEF.md
# SPI-Mode Card Block Transfer Controller

This is a host-side engine that runs the data phase of block reads and writes to a memory card in its byte-serial SPI mode. Another block sends the command and checks the command response. It then starts this controller with a direction, a single/multi flag, a block count and a block length. The controller drives a byte-exchange port. Each request sends one byte and later returns the byte received in the same eight clocks. It also holds chip select low (active) for the whole data phase, streams bytes to or from a buffer, and reports one error code when the operation ends.

On a read the controller clocks out 0xFF filler while it hunts for a start token. It accepts either a start token or an error token, receives the block, and checks the trailing 16-bit CRC. On a write it sends a start token, the block and the CRC. It then decodes the data-response token and polls while the card holds the line low during programming. A multi-block write is closed with a stop token, one ignored byte and a final busy wait.

States and transitions: `ST_IDLE` goes to `ST_RD_HUNT` or `ST_WR_TOKEN` on a start. The read path is `ST_RD_HUNT` → `ST_RD_DATA` → `ST_RD_CRC` → `ST_RD_CHECK`. From `ST_RD_CHECK` it goes back to `ST_RD_HUNT` while blocks remain, otherwise to `ST_DONE`. The write path is `ST_WR_TOKEN` → `ST_WR_DATA` → `ST_WR_CRC` → `ST_WR_RESP` → `ST_WR_BUSY`. From `ST_WR_BUSY` it goes to `ST_WR_TOKEN` while blocks remain. After the last block it goes to `ST_DONE` for a single write, or to `ST_WR_STOP` → `ST_STOP_GAP` → `ST_STOP_BUSY` → `ST_DONE` for a multi write. Every error or timeout goes straight to `ST_DONE`. `ST_DONE` returns to `ST_IDLE`.

Top module: `spicard_blk_xfer`

## Requirements
- R1: After reset `cs_n` is 1, and `op_busy`, `op_done` and `xb_req` are 0.
- R2: `cs_n` is 0 from the cycle after an accepted start until the operation returns to idle, and 1 otherwise. Every `xb_req` occurs with `cs_n` at 0, and a new exchange is requested only after the previous one has returned `xb_done`.
- R3: While hunting for a read token, the controller sends 0xFF on each exchange, with these outcomes:
  - 0xFE starts the block.
  - A byte with upper nibble 0 and a non-zero lower nibble is an error token. It ends the operation with code 2 and no data.
  - Any other byte is filler.
  - `TOKEN_POLLS` consecutive filler bytes end the operation with code 1.
- R4: A read block delivers exactly `blk_len` bytes in arrival order, one `rd_valid` pulse each, while sending 0xFF. Two CRC bytes follow, high byte first. The CRC is computed MSB first over the data with polynomial 0x1021 and initial value 0. If it does not match, the operation ends with code 3.
- R5: A multi-block read (`op_multi`=1) transfers `op_blocks` blocks. Each block has its own token hunt and its own CRC check. A single read transfers one block.
- R6: A write block sends start token 0xFE for a single write and 0xFC for each block of a multi write. It then sends `blk_len` bytes taken in order from `wr_data`, one `wr_take` pulse per byte. The two CRC bytes of R4 follow, high byte first.
- R7: After the CRC the controller sends 0xFF and reads the data-response token. A byte with bit 4 = 0 and bit 0 = 1 is a token, and bits 3:1 hold its status:
  - 010 means accepted, and the controller moves on to the busy wait.
  - 101 ends the operation with code 4.
  - 110 ends the operation with code 5.
  - Any other status ends it with code 7.
  - Bytes that are not tokens are filler. `TOKEN_POLLS` of them end the operation with code 7.
- R8: During the busy wait the controller sends 0xFF until a non-zero byte arrives. `BUSY_POLLS` consecutive 0x00 bytes end the operation with code 6.
- R9: After the last block of a multi write the controller sends stop token 0xFD. It then sends one 0xFF whose received byte is ignored, then waits out busy as in R8 before finishing.
- R10: `op_done` is a one-cycle pulse at the end of each operation. `op_err` (0 on success) changes only at that point and holds until the next operation ends. `op_start` while `op_busy` is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | Start pulse, accepted in idle |
| op_write | input | 1 | 1 = write, 0 = read |
| op_multi | input | 1 | 1 = multi-block operation |
| op_blocks | input | CNT_W | Block count for multi operations (at least 1) |
| blk_len | input | LEN_W | Bytes per block (at least 1) |
| op_busy | output | 1 | Operation in progress |
| op_done | output | 1 | One-cycle end-of-operation pulse |
| op_err | output | 3 | Result code of the last operation |
| cs_n | output | 1 | Card chip select, active low |
| xb_req | output | 1 | Byte exchange request |
| xb_tx | output | 8 | Byte to send with the request |
| xb_done | input | 1 | Exchange finished, `xb_rx` valid |
| xb_rx | input | 8 | Byte received in the exchange |
| wr_data | input | 8 | Current write buffer byte |
| wr_take | output | 1 | Write byte consumed |
| rd_valid | output | 1 | Read data byte valid |
| rd_data | output | 8 | Read data byte |

## Verification
Each read is preceded by a random number of filler bytes and uses random block lengths, including length 1, so the tests exercise both the token hunt and the byte counter boundary. Correct data and a zero error code show that hunting and block counting are right. Single-bit CRC corruption, an error token, and a silent card then separate the three read failure codes. Writes use each data-response status, a missing busy release, and random busy lengths. In multi writes the byte after the stop token is non-zero, so the test shows whether it is ignored or taken as the end of busy. Random mixes of the two directions and single/multi modes check that the byte stream sent matches the bench's own framing model, byte for byte.

// File: rtl/spicard_xfer_pkg.sv
package spicard_xfer_pkg;

    localparam logic [7:0] TOK_FILL     = 8'hFF;
    localparam logic [7:0] TOK_START    = 8'hFE;
    localparam logic [7:0] TOK_MULTI_WR = 8'hFC;
    localparam logic [7:0] TOK_STOP     = 8'hFD;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_HUNT,
        ST_RD_DATA,
        ST_RD_CRC,
        ST_RD_CHECK,
        ST_WR_TOKEN,
        ST_WR_DATA,
        ST_WR_CRC,
        ST_WR_RESP,
        ST_WR_BUSY,
        ST_WR_STOP,
        ST_STOP_GAP,
        ST_STOP_BUSY,
        ST_DONE
    } xfer_state_e;

    typedef enum logic [2:0] {
        ERR_NONE          = 3'd0,
        ERR_TOKEN_TIMEOUT = 3'd1,
        ERR_CARD_TOKEN    = 3'd2,
        ERR_RD_CRC        = 3'd3,
        ERR_WR_CRC        = 3'd4,
        ERR_WR_FAIL       = 3'd5,
        ERR_BUSY_TIMEOUT  = 3'd6,
        ERR_RESP_BAD      = 3'd7
    } xfer_err_e;

    // One byte of CRC16 (poly 0x1021), most significant bit first.
    function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[15] ^ d[i];
            r  = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

endpackage

// File: rtl/spicard_crc16_acc.sv
module spicard_crc16_acc (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    import spicard_xfer_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= '0;
        end else if (clr) begin
            crc <= '0;
        end else if (en) begin
            crc <= crc16_byte(crc, din);
        end
    end

endmodule

// File: rtl/spicard_poll_timer.sv
module spicard_poll_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign last = (cnt_q == limit - W'(1));

    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < limit);  // R8

endmodule

// File: rtl/spicard_blk_xfer.sv
module spicard_blk_xfer #(
    parameter int LEN_W       = 12,
    parameter int CNT_W       = 8,
    parameter int TOKEN_POLLS = 256,
    parameter int BUSY_POLLS  = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_start,
    input  logic             op_write,
    input  logic             op_multi,
    input  logic [CNT_W-1:0] op_blocks,
    input  logic [LEN_W-1:0] blk_len,
    output logic             op_busy,
    output logic             op_done,
    output logic [2:0]       op_err,
    output logic             cs_n,
    output logic             xb_req,
    output logic [7:0]       xb_tx,
    input  logic             xb_done,
    input  logic [7:0]       xb_rx,
    input  logic [7:0]       wr_data,
    output logic             wr_take,
    output logic             rd_valid,
    output logic [7:0]       rd_data
);
    import spicard_xfer_pkg::*;

    localparam int MAX_POLLS = (TOKEN_POLLS > BUSY_POLLS) ? TOKEN_POLLS : BUSY_POLLS;
    localparam int POLL_W    = $clog2(MAX_POLLS + 1);

    xfer_state_e      state_q, state_d;
    xfer_err_e        err_q, err_d;
    logic             waiting_q, waiting_d;
    logic             wr_q, multi_q, cs_n_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] byte_cnt_q, byte_cnt_d;
    logic [CNT_W-1:0] blk_left_q, blk_left_d;

    logic             byte_state, issue, got, last_byte;
    logic             crc_clr, crc_en;
    logic [7:0]       crc_din;
    logic [15:0]      crc_val;
    logic             poll_clr, poll_tick, poll_last;
    logic [POLL_W-1:0] poll_limit;

    assign byte_state = !(state_q inside {ST_IDLE, ST_RD_CHECK, ST_DONE});
    assign issue      = byte_state && !waiting_q;
    assign got        = waiting_q && xb_done;
    assign last_byte  = (byte_cnt_q == len_q - LEN_W'(1));
    assign poll_limit = (state_q inside {ST_WR_BUSY, ST_STOP_BUSY}) ?
                        POLL_W'(BUSY_POLLS) : POLL_W'(TOKEN_POLLS);
    assign poll_clr   = (state_d != state_q);

    spicard_crc16_acc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_en),
        .din   (crc_din),
        .crc   (crc_val)
    );

    spicard_poll_timer #(.W(POLL_W)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (poll_clr),
        .tick  (poll_tick),
        .limit (poll_limit),
        .last  (poll_last)
    );

    // State and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            err_q      <= ERR_NONE;
            waiting_q  <= 1'b0;
            wr_q       <= 1'b0;
            multi_q    <= 1'b0;
            cs_n_q     <= 1'b1;
            len_q      <= '0;
            byte_cnt_q <= '0;
            blk_left_q <= '0;
        end else begin
            state_q    <= state_d;
            err_q      <= err_d;
            waiting_q  <= waiting_d;
            cs_n_q     <= (state_d == ST_IDLE);
            byte_cnt_q <= byte_cnt_d;
            blk_left_q <= blk_left_d;
            if (state_q == ST_IDLE && op_start) begin
                wr_q    <= op_write;
                multi_q <= op_multi;
                len_q   <= blk_len;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        state_d    = state_q;
        err_d      = err_q;
        byte_cnt_d = byte_cnt_q;
        blk_left_d = blk_left_q;
        waiting_d  = waiting_q;
        xb_tx      = TOK_FILL;
        wr_take    = 1'b0;
        rd_valid   = 1'b0;
        crc_clr    = 1'b0;
        crc_en     = 1'b0;
        crc_din    = xb_rx;
        poll_tick  = 1'b0;

        if (issue) waiting_d = 1'b1;
        else if (got) waiting_d = 1'b0;

        unique case (state_q)
            ST_IDLE: begin
                if (op_start) begin
                    state_d    = op_write ? ST_WR_TOKEN : ST_RD_HUNT;
                    blk_left_d = op_multi ? op_blocks : CNT_W'(1);
                    byte_cnt_d = '0;
                    crc_clr    = 1'b1;
                end
            end
            ST_RD_HUNT: begin
                if (got) begin
                    if (xb_rx == TOK_START) begin
                        state_d    = ST_RD_DATA;
                        byte_cnt_d = '0;
                    end else if (xb_rx[7:4] == 4'h0 && xb_rx[3:0] != 4'h0) begin
                        err_d   = ERR_CARD_TOKEN;
                        state_d = ST_DONE;
                    end else if (poll_last) begin
                        err_d   = ERR_TOKEN_TIMEOUT;
                        state_d = ST_DONE;
                    end else begin
                        poll_tick = 1'b1;
                    end
                end
            end
            ST_RD_DATA: begin
                if (got) begin
                    rd_valid = 1'b1;
                    crc_en   = 1'b1;
                    if (last_byte) begin
                        state_d    = ST_RD_CRC;
                        byte_cnt_d = '0;
                    end else begin
                        byte_cnt_d = byte_cnt_q + LEN_W'(1);
                    end
                end
            end
            ST_RD_CRC: begin
                if (got) begin
                    crc_en = 1'b1;
                    if (byte_cnt_q[0]) state_d = ST_RD_CHECK;
                    else byte_cnt_d = LEN_W'(1);
                end
            end
            ST_RD_CHECK: begin
                if (crc_val != 16'h0000) begin
                    err_d   = ERR_RD_CRC;
                    state_d = ST_DONE;
                end else if (blk_left_q == CNT_W'(1)) begin
                    err_d   = ERR_NONE;
                    state_d = ST_DONE;
                end else begin
                    blk_left_d = blk_left_q - CNT_W'(1);
                    crc_clr    = 1'b1;
                    state_d    = ST_RD_HUNT;
                end
            end
            ST_WR_TOKEN: begin
                xb_tx   = multi_q ? TOK_MULTI_WR : TOK_START;
                crc_clr = 1'b1;
                if (got) begin
                    state_d    = ST_WR_DATA;
                    byte_cnt_d = '0;
                end
            end
            ST_WR_DATA: begin
                xb_tx = wr_data;
                if (issue) begin
                    wr_take = 1'b1;
                    crc_en  = 1'b1;
                    crc_din = wr_data;
                end
                if (got) begin
                    if (last_byte) begin
                        state_d    = ST_WR_CRC;
                        byte_cnt_d = '0;
                    end else begin
                        byte_cnt_d = byte_cnt_q + LEN_W'(1);
                    end
                end
            end
            ST_WR_CRC: begin
                xb_tx = byte_cnt_q[0] ? crc_val[7:0] : crc_val[15:8];
                if (got) begin
                    if (byte_cnt_q[0]) state_d = ST_WR_RESP;
                    else byte_cnt_d = LEN_W'(1);
                end
            end
            ST_WR_RESP: begin
                if (got) begin
                    if (!xb_rx[4] && xb_rx[0]) begin
                        state_d = ST_DONE;
                        unique case (xb_rx[3:1])
                            3'b010:  state_d = ST_WR_BUSY;
                            3'b101:  err_d = ERR_WR_CRC;
                            3'b110:  err_d = ERR_WR_FAIL;
                            default: err_d = ERR_RESP_BAD;
                        endcase
                    end else if (poll_last) begin
                        err_d   = ERR_RESP_BAD;
                        state_d = ST_DONE;
                    end else begin
                        poll_tick = 1'b1;
                    end
                end
            end
            ST_WR_BUSY: begin
                if (got) begin
                    if (xb_rx != 8'h00) begin
                        if (blk_left_q != CNT_W'(1)) begin
                            blk_left_d = blk_left_q - CNT_W'(1);
                            state_d    = ST_WR_TOKEN;
                        end else if (multi_q) begin
                            state_d = ST_WR_STOP;
                        end else begin
                            err_d   = ERR_NONE;
                            state_d = ST_DONE;
                        end
                    end else if (poll_last) begin
                        err_d   = ERR_BUSY_TIMEOUT;
                        state_d = ST_DONE;
                    end else begin
                        poll_tick = 1'b1;
                    end
                end
            end
            ST_WR_STOP: begin
                xb_tx = TOK_STOP;
                if (got) state_d = ST_STOP_GAP;
            end
            ST_STOP_GAP: begin
                if (got) state_d = ST_STOP_BUSY;
            end
            ST_STOP_BUSY: begin
                if (got) begin
                    if (xb_rx != 8'h00) begin
                        err_d   = ERR_NONE;
                        state_d = ST_DONE;
                    end else if (poll_last) begin
                        err_d   = ERR_BUSY_TIMEOUT;
                        state_d = ST_DONE;
                    end else begin
                        poll_tick = 1'b1;
                    end
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign xb_req  = issue;
    assign op_busy = (state_q != ST_IDLE);
    assign op_done = (state_q == ST_DONE);
    assign op_err  = err_q;
    assign cs_n    = cs_n_q;
    assign rd_data = xb_rx;

    AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !op_busy |-> cs_n);  // R2
    AST_REQ_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        xb_req |-> !cs_n);  // R2
    AST_REQ_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        xb_req |=> !xb_req);  // R2
    AST_START_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && !op_busy) |=> !cs_n);  // R2
    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);  // R4
    AST_TAKE_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |-> (xb_req && wr_q));  // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);  // R10
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_busy && !op_start) |=> $stable(op_err));  // R10

endmodule

// File: tb/spicard_blk_xfer_tb.sv
module spicard_blk_xfer_tb_top;

    localparam int TP = 8;
    localparam int BP = 16;
    localparam int AW = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_start = 1'b0, op_write = 1'b0, op_multi = 1'b0;
    logic [7:0] op_blocks = 8'd1;
    logic [11:0] blk_len = 12'd1;
    logic       op_busy, op_done, cs_n, xb_req, wr_take, rd_valid;
    logic [2:0] op_err;
    logic [7:0] xb_tx, rd_data, wr_data;
    logic       xb_done = 1'b0;
    logic [7:0] xb_rx = 8'hFF;

    logic [7:0] rsp [AW];
    logic [7:0] exp_tx [AW];
    logic [7:0] exp_rd [AW];
    logic [7:0] txlog [AW];
    logic [7:0] rdlog [AW];
    logic [7:0] wsrc [AW];
    int rsp_n, ex_n, er_n, tx_n, rd_n, ridx, widx, cs_bad, done_cnt, wsrc_n;
    logic [7:0] rsp_dflt;
    bit take_pend, m_busy, done_seen;
    int m_lat;
    logic [2:0] got_err;
    int n_chk, n_fail;

    always #5 clk = ~clk;

    assign wr_data = wsrc[widx];

    spicard_blk_xfer #(.LEN_W(12), .CNT_W(8), .TOKEN_POLLS(TP), .BUSY_POLLS(BP)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_write(op_write),
        .op_multi(op_multi), .op_blocks(op_blocks), .blk_len(blk_len),
        .op_busy(op_busy), .op_done(op_done), .op_err(op_err), .cs_n(cs_n),
        .xb_req(xb_req), .xb_tx(xb_tx), .xb_done(xb_done), .xb_rx(xb_rx),
        .wr_data(wr_data), .wr_take(wr_take), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // Card-side byte exchange model, driven at the falling edge
    always @(negedge clk) begin
        xb_done = 1'b0;
        if (take_pend) begin
            widx++;
            take_pend = 1'b0;
        end
        if (m_busy) begin
            if (m_lat == 0) begin
                xb_rx = (ridx < rsp_n) ? rsp[ridx] : rsp_dflt;
                ridx++;
                xb_done = 1'b1;
                m_busy = 1'b0;
            end else begin
                m_lat--;
            end
        end else if (xb_req) begin
            if (tx_n < AW) txlog[tx_n] = xb_tx;
            tx_n++;
            if (cs_n) cs_bad++;
            if (wr_take) take_pend = 1'b1;
            m_busy = 1'b1;
            m_lat = int'($urandom % 3);
        end
    end

    // Output monitor, sampled mid-cycle
    always @(negedge clk) begin
        #3;
        if (rd_valid) begin
            if (rd_n < AW) rdlog[rd_n] = rd_data;
            rd_n++;
        end
        if (op_done) begin
            done_seen = 1'b1;
            done_cnt++;
            got_err = op_err;
        end
    end

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        logic fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[15] ^ d[i];
            r = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic check(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    task automatic pr(input logic [7:0] b);
        rsp[rsp_n] = b;
        rsp_n++;
    endtask

    task automatic px(input logic [7:0] b, input logic [7:0] r);
        exp_tx[ex_n] = b;
        ex_n++;
        pr(r);
    endtask

    task automatic clear_model();
        rsp_n = 0; ex_n = 0; er_n = 0; wsrc_n = 0; rsp_dflt = 8'hFF;
    endtask

    task automatic build_read(input int nb, input int len);
        logic [15:0] c;
        logic [7:0] d;
        clear_model();
        for (int b = 0; b < nb; b++) begin
            int nf;
            nf = int'($urandom % 3);
            for (int f = 0; f < nf; f++) px(8'hFF, (f == 0) ? 8'h00 : 8'hFF);
            px(8'hFF, 8'hFE);
            c = 16'h0000;
            for (int i = 0; i < len; i++) begin
                d = 8'($urandom);
                exp_rd[er_n] = d;
                er_n++;
                c = crc_upd(c, d);
                px(8'hFF, d);
            end
            px(8'hFF, c[15:8]);
            px(8'hFF, c[7:0]);
        end
    endtask

    task automatic build_write(input int nb, input int len, input bit m);
        logic [15:0] c;
        logic [7:0] d;
        int nz;
        clear_model();
        for (int b = 0; b < nb; b++) begin
            px(m ? 8'hFC : 8'hFE, 8'hFF);
            c = 16'h0000;
            for (int i = 0; i < len; i++) begin
                d = 8'($urandom);
                wsrc[wsrc_n] = d;
                wsrc_n++;
                c = crc_upd(c, d);
                px(d, 8'hFF);
            end
            px(c[15:8], 8'hFF);
            px(c[7:0], 8'hFF);
            px(8'hFF, 8'hE5);
            nz = int'($urandom % 3);
            for (int k = 0; k < nz; k++) px(8'hFF, 8'h00);
            px(8'hFF, 8'hFF);
        end
        if (m) begin
            px(8'hFD, 8'hFF);
            px(8'hFF, 8'hFF);
            px(8'hFF, 8'h00);
            px(8'hFF, 8'h00);
            px(8'hFF, 8'hFF);
        end
    endtask

    task automatic run_op(input bit w, input bit m, input int nb, input int len, input bit poke);
        tx_n = 0; rd_n = 0; ridx = 0; widx = 0; take_pend = 1'b0; done_seen = 1'b0;
        @(negedge clk);
        op_write = w; op_multi = m; op_blocks = 8'(nb); blk_len = 12'(len); op_start = 1'b1;
        @(negedge clk);
        op_start = 1'b0;
        if (poke) begin
            repeat (4) @(negedge clk);
            op_start = 1'b1; op_write = !w; op_multi = !m;
            @(negedge clk);
            op_start = 1'b0; op_write = w; op_multi = m;
        end
        while (!done_seen) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    function automatic int tx_mism();
        int n;
        n = 0;
        for (int i = 0; i < ex_n && i < AW; i++) if (txlog[i] != exp_tx[i]) n++;
        return n;
    endfunction

    function automatic int rd_mism();
        int n;
        n = 0;
        for (int i = 0; i < er_n && i < AW; i++) if (rdlog[i] != exp_rd[i]) n++;
        return n;
    endfunction

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual 0x0 expected 0x1");
        report();
        $finish;
    end

    initial begin
        int len, d0;
        void'($urandom(32'd4242));
        n_chk = 0; n_fail = 0; cs_bad = 0; done_cnt = 0;
        m_busy = 1'b0; take_pend = 1'b0; done_seen = 1'b0;
        clear_model();
        repeat (3) @(negedge clk);
        check("R1 cs_n in reset", int'(cs_n), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 cs_n idle", int'(cs_n), 1);
        check("R1 op_busy idle", int'(op_busy), 0);
        check("R1 xb_req idle", int'(xb_req), 0);
        check("R1 op_done idle", int'(op_done), 0);

        // Single read with filler before the token
        len = 16;
        build_read(1, len);
        run_op(1'b0, 1'b0, 1, len, 1'b0);
        check("R4 read err", int'(got_err), 0);
        check("R4 read count", rd_n, len);
        check("R4 read data", rd_mism(), 0);
        check("R3 read filler bytes", tx_mism(), 0);
        check("R3 read exchanges", tx_n, ex_n);
        check("R2 cs_n after op", int'(cs_n), 1);

        // Error token in place of data
        clear_model();
        pr(8'hFF); pr(8'h07);
        run_op(1'b0, 1'b0, 1, 8, 1'b0);
        check("R3 error token code", int'(got_err), 2);
        check("R3 error token no data", rd_n, 0);
        check("R3 error token exchanges", tx_n, 2);

        // Start token never arrives
        clear_model();
        run_op(1'b0, 1'b0, 1, 8, 1'b0);
        check("R3 token timeout code", int'(got_err), 1);
        check("R3 token timeout polls", tx_n, TP);

        // Corrupted CRC
        build_read(1, 10);
        rsp[rsp_n-1] = rsp[rsp_n-1] ^ 8'h01;
        run_op(1'b0, 1'b0, 1, 10, 1'b0);
        check("R4 crc mismatch code", int'(got_err), 3);
        check("R4 crc mismatch data", rd_n, 10);

        // Multi-block read, length 1 boundary, plus start while busy
        d0 = done_cnt;
        build_read(3, 1);
        run_op(1'b0, 1'b1, 3, 1, 1'b1);
        check("R5 multi read err", int'(got_err), 0);
        check("R5 multi read count", rd_n, 3);
        check("R5 multi read data", rd_mism(), 0);
        check("R10 start while busy ignored", tx_mism(), 0);
        check("R10 one done per op", done_cnt - d0, 1);

        // Single write accepted
        len = 4 + int'($urandom % 20);
        build_write(1, len, 1'b0);
        run_op(1'b1, 1'b0, 1, len, 1'b0);
        check("R6 write err", int'(got_err), 0);
        check("R6 write stream", tx_mism(), 0);
        check("R8 write exchanges", tx_n, ex_n);
        check("R6 write takes", widx, len);

        // Data-response rejections
        build_write(1, 6, 1'b0);
        rsp[9] = 8'h0B; rsp_n = 10;
        run_op(1'b1, 1'b0, 1, 6, 1'b0);
        check("R7 crc reject code", int'(got_err), 4);
        check("R7 crc reject exchanges", tx_n, 10);
        build_write(1, 6, 1'b0);
        rsp[9] = 8'h0D; rsp_n = 10;
        run_op(1'b1, 1'b0, 1, 6, 1'b0);
        check("R7 write fail code", int'(got_err), 5);
        build_write(1, 6, 1'b0);
        rsp[9] = 8'h0F; rsp_n = 10;
        run_op(1'b1, 1'b0, 1, 6, 1'b0);
        check("R7 bad status code", int'(got_err), 7);

        // Busy never released
        build_write(1, 6, 1'b0);
        rsp_n = 10; rsp_dflt = 8'h00;
        run_op(1'b1, 1'b0, 1, 6, 1'b0);
        check("R8 busy timeout code", int'(got_err), 6);
        check("R8 busy timeout polls", tx_n, 10 + BP);

        // Multi-block write with stop token; gap byte is non-zero
        build_write(2, 5, 1'b1);
        run_op(1'b1, 1'b1, 2, 5, 1'b0);
        check("R9 multi write err", int'(got_err), 0);
        check("R9 multi write stream", tx_mism(), 0);
        check("R9 multi write exchanges", tx_n, ex_n);
        check("R6 multi write takes", widx, 10);

        // Random mix
        for (int it = 0; it < 8; it++) begin
            bit w, m;
            int nb;
            w = 1'($urandom);
            m = 1'($urandom);
            nb = m ? 1 + int'($urandom % 3) : 1;
            len = 1 + int'($urandom % 20);
            if (w) build_write(nb, len, m);
            else build_read(nb, len);
            run_op(w, m, nb, len, 1'b0);
            check(w ? "R6 random write err" : "R5 random read err", int'(got_err), 0);
            check(w ? "R6 random write stream" : "R3 random read stream", tx_mism(), 0);
            check(w ? "R6 random write count" : "R4 random read count", w ? widx : rd_n, nb * len);
            if (!w) check("R4 random read data", rd_mism(), 0);
        end

        check("R2 cs_n low on every request", cs_bad, 0);
        report();
        $finish;
    end

endmodule